// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block is the slave-side front end of a three-wire serial port made of a chip-select, a serial clock driven by the host, and one data line that can be turned around. It brings chip-select, serial clock and data into a faster system clock. It samples one data bit on each rising serial clock edge. It opens a session only when a six-bit unlock pattern arrives first.

The pattern's fifth bit is a free update-control flag. The block captures this flag and exports it. Once a session is open, the block frames the bit stream into 16-bit control words and gives each one a single-cycle strobe. A read command turns the data line into an output. The data line then drives the stored bit that the command's address field selects, with the storage array sitting outside the block. Lowering chip-select ends the session. A wrong unlock pattern keeps the port deaf until chip-select is lowered and raised again.

Top module: `serial_cmd_rx`

## Requirements
- R1: While reset is held and directly after it, `session_active`, `word_valid`, `dio_oe`, `dio_out` and `upd_flag` are all 0.
- R2: After chip-select rises, the first six sampled bits, in time order, must be 1,0,1,0,U,0. When they are, `session_active` goes high and stays high while chip-select stays high.
- R3: A wrong value at any of the five fixed positions of the unlock pattern locks the port. `session_active` stays low and no word is reported until chip-select goes low, goes high again and a correct pattern follows.
- R4: `upd_flag` takes the U bit of each correct unlock pattern. A rejected pattern leaves it unchanged.
- R5: In a session, every 16 sampled bits form one word, shifted least significant bit first, so the k-th bit received lands in `word_data[k]`. Each word gives exactly one single-cycle `word_valid` pulse, and back-to-back words are all reported.
- R6: When chip-select falls, `session_active` clears and any partly received word is discarded. The next session frames its words from bit 0.
- R7: A word whose bits [15:12] equal 4'b1011 is a read command. `rd_addr` then takes bits [5:0], `dio_oe` goes high, and `dio_out` follows `rd_bit`. `dio_out` is 0 whenever `dio_oe` is low.
- R8: `dio_oe` is low while chip-select is low. It is still low after chip-select rises again, so the data line is back in input mode.
- R9: A word with any other command value leaves `dio_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_in | input | 1 | Chip-select, asynchronous, active high |
| sclk_in | input | 1 | Serial clock, asynchronous; data sampled on its rising edge |
| dio_in | input | 1 | Data line as seen at the pad |
| rd_bit | input | 1 | Stored bit at `rd_addr`, from the storage array |
| dio_out | output | 1 | Value driven onto the data line |
| dio_oe | output | 1 | Output enable for the data line pad |
| rd_addr | output | 6 | Address taken from the last read command |
| word_data | output | 16 | Last completed control word |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| upd_flag | output | 1 | U bit of the last accepted unlock pattern |
| session_active | output | 1 | High while a session is open |

## Verification
The bench drives all 64 six-bit headers. A detector that checks one position too few would open a session on a bad header. One with the bit order reversed would reject the legal ones. The bench also checks that a bad header neither changes the exported flag nor lets a following word through.

A session is cut seven bits into a word, and the next word must arrive intact. A counter that is not cleared on the new session would misframe that word. A sweep over every address and every non-read command catches a wrong command field or a wrong address slice. It also catches an output enable that survives a chip-select cycle.

// File: rtl/serial_cmd_pkg.sv
// Shared types and constants for the framed serial command receiver.
package serial_cmd_pkg;

    // Session state of the frame controller
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,   // chip-select low, nothing accepted
        FR_HDR  = 2'd1,   // checking the unlock pattern
        FR_LOCK = 2'd2,   // bad pattern seen, ignore data
        FR_RUN  = 2'd3    // session open, words accepted
    } frame_st_t;

    localparam int          HDR_LEN  = 6;
    localparam int          HDR_CW   = 3;
    // Bit i of these vectors belongs to the i-th received header bit
    localparam logic [5:0]  HDR_MASK = 6'b101111;  // position 4 is free
    localparam logic [5:0]  HDR_VAL  = 6'b000101;  // 1,0,1,0,x,0 in time order
    localparam int          UPD_POS  = 4;

    // True when header bit b is acceptable at position pos
    function automatic logic hdr_bit_ok(input logic [HDR_CW-1:0] pos, input logic b);
        return (!HDR_MASK[pos]) || (b == HDR_VAL[pos]);
    endfunction

endpackage

// File: rtl/scr_sync_edge.sv
// Multi-flop synchroniser with edge detection for a bundle of async inputs.
// Assumes each input is slow compared to clk (stable for several cycles).
module scr_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES-1:0][WIDTH-1:0] stg;
    logic [WIDTH-1:0]             prev;

    // Shift inputs through the synchroniser chain and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg  <= '0;
            prev <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    // Edge pulses from the settled level and its delayed copy
    always_comb begin
        level = stg[STAGES-1];
        rise  = level & ~prev;
        fall  = ~level & prev;
    end
endmodule

// File: rtl/scr_frame_ctrl.sv
// Session controller: checks the six-bit unlock pattern after each
// chip-select rise, captures the update flag, and forwards bit strobes to
// the word framer only while a session is open.
// Assumes chip-select edges and serial clock edges never share a cycle;
// if they do, the chip-select edge wins and the bit is dropped.
module scr_frame_ctrl
    import serial_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic bit_stb,
    input  logic bit_val,
    output logic bit_fwd,
    output logic run,
    output logic upd_flag
);
    frame_st_t          state;
    logic [HDR_CW-1:0]  hdr_cnt;
    logic               u_tmp;

    // Session state machine and header checking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FR_IDLE;
            hdr_cnt  <= '0;
            u_tmp    <= 1'b0;
            upd_flag <= 1'b0;
        end else if (cs_fall) begin
            state <= FR_IDLE;
        end else if (cs_rise) begin
            state   <= FR_HDR;
            hdr_cnt <= '0;
        end else if (bit_stb && state == FR_HDR) begin
            if (!hdr_bit_ok(hdr_cnt, bit_val)) begin
                state <= FR_LOCK;
            end else begin
                if (hdr_cnt == HDR_CW'(UPD_POS)) begin
                    u_tmp <= bit_val;
                end
                if (hdr_cnt == HDR_CW'(HDR_LEN - 1)) begin
                    state    <= FR_RUN;
                    upd_flag <= u_tmp;
                end
                hdr_cnt <= hdr_cnt + 1'b1;
            end
        end
    end

    // Forward sampled bits to the framer only inside an open session
    always_comb begin
        run     = (state == FR_RUN);
        bit_fwd = bit_stb && run && !cs_fall && !cs_rise;
    end
endmodule

// File: rtl/scr_word_shift.sv
// Word framer: assembles LSB-first bits into WORD_W-bit words and pulses
// valid for one cycle when the last bit of a word lands.
// Assumes clear is pulsed at every session start to drop partial words.
module scr_word_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int CW = $clog2(WORD_W);

    logic [WORD_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] nxt;

    // Next shift value: newest bit enters at the top
    always_comb nxt = {bit_val, sh[WORD_W-1:1]};

    // Shift, count and publish completed words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            cnt   <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                cnt <= '0;
                sh  <= '0;
            end else if (bit_stb) begin
                sh <= nxt;
                if (cnt == CW'(WORD_W - 1)) begin
                    cnt   <= '0;
                    word  <= nxt;
                    valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/scr_dio_dir.sv
// Data line direction control: a read command turns the line into an
// output and latches the address; chip-select low returns it to input.
// Assumes the command field sits in the top CMD_W bits of each word.
module scr_dio_dir #(
    parameter int              WORD_W   = 16,
    parameter int              CMD_W    = 4,
    parameter int              ADDR_W   = 6,
    parameter logic [CMD_W-1:0] READ_CMD = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_level,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              oe
);
    localparam int CMD_LSB = WORD_W - CMD_W;

    logic rd_mode;
    logic is_read;

    // Decode the command field of the current word
    always_comb is_read = (word[WORD_W-1:CMD_LSB] == READ_CMD);

    // Enter output mode on a read, leave it whenever chip-select is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode <= 1'b0;
            rd_addr <= '0;
        end else if (!cs_level) begin
            rd_mode <= 1'b0;
        end else if (word_valid && is_read) begin
            rd_mode <= 1'b1;
            rd_addr <= word[ADDR_W-1:0];
        end
    end

    // Output enable is gated by the live chip-select level
    always_comb oe = rd_mode && cs_level;
endmodule

// File: rtl/serial_cmd_rx.sv
// Top of the framed serial command receiver. Synchronises the three pad
// inputs, opens sessions on a valid unlock pattern, frames control words
// and steers the data line for read commands.
// Assumes clk runs several times faster than the serial clock.
module serial_cmd_rx #(
    parameter int               WORD_W   = 16,
    parameter int               CMD_W    = 4,
    parameter int               ADDR_W   = 6,
    parameter int               SYNC_N   = 2,
    parameter logic [CMD_W-1:0] READ_CMD = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_in,
    input  logic              sclk_in,
    input  logic              dio_in,
    input  logic              rd_bit,
    output logic              dio_out,
    output logic              dio_oe,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              upd_flag,
    output logic              session_active
);
    localparam int IDX_CS = 0;
    localparam int IDX_SC = 1;
    localparam int IDX_DI = 2;

    logic [2:0] s_lvl, s_rise, s_fall;
    logic       bit_fwd;

    scr_sync_edge #(.WIDTH(3), .STAGES(SYNC_N)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({dio_in, sclk_in, cs_in}),
        .level (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    scr_frame_ctrl i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (s_rise[IDX_CS]),
        .cs_fall  (s_fall[IDX_CS]),
        .bit_stb  (s_rise[IDX_SC]),
        .bit_val  (s_lvl[IDX_DI]),
        .bit_fwd  (bit_fwd),
        .run      (session_active),
        .upd_flag (upd_flag)
    );

    scr_word_shift #(.WORD_W(WORD_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (s_rise[IDX_CS]),
        .bit_stb (bit_fwd),
        .bit_val (s_lvl[IDX_DI]),
        .word    (word_data),
        .valid   (word_valid)
    );

    scr_dio_dir #(
        .WORD_W(WORD_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .READ_CMD(READ_CMD)
    ) i_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_level   (s_lvl[IDX_CS]),
        .word_valid (word_valid),
        .word       (word_data),
        .rd_addr    (rd_addr),
        .oe         (dio_oe)
    );

    // Drive the stored bit only while the pad is enabled
    always_comb dio_out = dio_oe && rd_bit;

    logic unused_edges;
    always_comb unused_edges = ^{s_lvl[IDX_SC], s_fall[IDX_SC], s_rise[IDX_DI], s_fall[IDX_DI]};
endmodule

// File: rtl/serial_cmd_rx_chk.sv
// Assertion checker for serial_cmd_rx, attached through bind.
module serial_cmd_rx_chk #(
    parameter int               WORD_W   = 16,
    parameter int               CMD_W    = 4,
    parameter int               ADDR_W   = 6,
    parameter logic [CMD_W-1:0] READ_CMD = 4'b1011
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dio_out,
    input logic              dio_oe,
    input logic [WORD_W-1:0] word_data,
    input logic              word_valid,
    input logic              upd_flag,
    input logic              session_active
);
    // R5
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R3
    word_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> session_active);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(session_active) |-> $stable(upd_flag));

    // R8
    oe_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dio_oe |-> session_active);

    // R7
    oe_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dio_oe) |-> ($past(word_valid) && ($past(word_data[WORD_W-1 -: CMD_W]) == READ_CMD)));

    // R7
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dio_oe |-> !dio_out);
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(
    .WORD_W(WORD_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .READ_CMD(READ_CMD)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dio_out        (dio_out),
    .dio_oe         (dio_oe),
    .word_data      (word_data),
    .word_valid     (word_valid),
    .upd_flag       (upd_flag),
    .session_active (session_active)
);

// File: tb/test_serial_cmd_rx.sv
module test_serial_cmd_rx;
    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_in = 1'b0, sclk_in = 1'b0, dio_in = 1'b0;
    logic        rd_bit;
    logic        dio_out, dio_oe, word_valid, upd_flag, session_active;
    logic [5:0]  rd_addr;
    logic [15:0] word_data;

    int total = 0, bad = 0, nwords = 0, cyc = 0;
    logic [15:0] last_word = '0;
    bit done = 0;

    always #5 clk = ~clk;

    // Storage model: bit value computed from the address
    function automatic logic mem_bit(input logic [5:0] a);
        return ^(a & 6'b101101) ^ a[1];
    endfunction
    assign rd_bit = mem_bit(rd_addr);

    serial_cmd_rx i_serial_cmd_rx (
        .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .sclk_in(sclk_in), .dio_in(dio_in),
        .rd_bit(rd_bit), .dio_out(dio_out), .dio_oe(dio_oe), .rd_addr(rd_addr),
        .word_data(word_data), .word_valid(word_valid), .upd_flag(upd_flag),
        .session_active(session_active)
    );

    // Word monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            nwords = nwords + 1;
            last_word = word_data;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_set(input logic v);
        cs_in = v;
        repeat (8) @(posedge clk);
    endtask

    task automatic send_bit(input logic b);
        dio_in = b;
        repeat (HP) @(posedge clk);
        sclk_in = 1'b1;
        repeat (HP) @(posedge clk);
        sclk_in = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic send_hdr(input logic [5:0] p);
        for (int i = 0; i < 6; i++) send_bit(p[i]);
    endtask

    task automatic open_session(input logic u);
        cs_set(1'b0);
        cs_set(1'b1);
        send_hdr({1'b0, u, 4'b0101});
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 0; i < 16; i++) send_bit(w[i]);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        int n0;
        logic exp_u;
        logic [15:0] pats [6];
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!session_active && !word_valid && !dio_oe && !dio_out && !upd_flag, "R1",
              {session_active, word_valid, dio_oe, dio_out, upd_flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!session_active && !dio_oe && !upd_flag, "R1 after release",
              {session_active, dio_oe, upd_flag}, 0);

        // R2 R3 R4: all 64 headers, then one word each
        exp_u = 1'b0;
        for (int p = 0; p < 64; p++) begin
            logic [5:0] hp;
            bit good;
            hp = 6'(p);
            good = ((hp & 6'b101111) == 6'b000101);
            if (good) exp_u = hp[4];
            cs_set(1'b0);
            cs_set(1'b1);
            send_hdr(hp);
            @(negedge clk);
            check(session_active == good, good ? "R2 session open" : "R3 locked",
                  session_active, good);
            check(upd_flag == exp_u, "R4 flag", upd_flag, exp_u);
            n0 = nwords;
            send_word(16'h3C5A ^ 16'(p));
            @(negedge clk);
            check((nwords - n0) == (good ? 1 : 0), "R3 words gated", nwords - n0, good ? 1 : 0);
        end

        // R3 recovery after a locked session
        cs_set(1'b0); cs_set(1'b1);
        send_hdr(6'b000111);
        open_session(1'b1);
        @(negedge clk);
        check(session_active && upd_flag, "R3 recovery", {session_active, upd_flag}, 3);

        // R5 consecutive words, several patterns
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
        pats[3] = 16'h0001; pats[4] = 16'h8000; pats[5] = 16'h7E18;
        for (int k = 0; k < 6; k++) begin
            n0 = nwords;
            send_word(pats[k]);
            @(negedge clk);
            check(nwords == n0 + 1 && last_word == pats[k], "R5 word", last_word, pats[k]);
        end
        for (int k = 0; k < 16; k++) begin
            send_word(16'(1) << k);
            @(negedge clk);
            check(last_word == (16'(1) << k), "R5 walking one", last_word, 16'(1) << k);
        end

        // R6 partial word dropped on chip-select fall
        for (int k = 0; k < 7; k++) send_bit(1'b1);
        cs_set(1'b0);
        @(negedge clk);
        check(!session_active, "R6 session closed", session_active, 0);
        open_session(1'b0);
        n0 = nwords;
        send_word(16'h1234);
        @(negedge clk);
        check(nwords == n0 + 1 && last_word == 16'h1234, "R6 reframe", last_word, 16'h1234);
        check(upd_flag == 1'b0, "R4 flag cleared", upd_flag, 0);

        // R9 non-read commands leave the line as input
        for (int c = 0; c < 16; c++) begin
            if (c != 11) begin
                send_word({4'(c), 12'h03F});
                @(negedge clk);
                check(!dio_oe, "R9 no turnaround", dio_oe, 0);
            end
        end

        // R7 read sweep over every address
        for (int a = 0; a < 64; a++) begin
            send_word({4'b1011, 6'b0, 6'(a)});
            @(negedge clk);
            check(dio_oe && rd_addr == 6'(a) && dio_out == mem_bit(6'(a)), "R7 read",
                  {dio_oe, rd_addr, dio_out}, {1'b1, 6'(a), mem_bit(6'(a))});
        end

        // R8 chip-select cycle returns the line to input
        cs_set(1'b0);
        @(negedge clk);
        check(!dio_oe && !dio_out, "R8 cs low", dio_oe, 0);
        cs_set(1'b1);
        @(negedge clk);
        check(!dio_oe, "R8 cs high again", dio_oe, 0);
        send_hdr(6'b000101);
        @(negedge clk);
        check(!dio_oe && session_active, "R8 new session input", {dio_oe, session_active}, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule